// File: doc/BRIEF.md
# UART enhanced-feature control

This block sits beside the register file of a 16550-style UART and adds three optional features, all governed by a single feature-enable bit held in the interrupt-enable register. The first is a software reset that reaches only an external device: a modem-control bit is driven out on a reset output pin together with the hardware reset. The second is a power-down control that stops the UART's baud and oscillator clock enables while every register keeps its contents. The third is a pair of inverted transmit-ready and receive-ready flags placed into the interrupt-status byte.

The block holds its own copies of the interrupt-enable and modem-control registers, which are loaded from host write strobes and can be read back. It merges the ready flags into the status byte that the rest of the UART produces. The serial datapath is outside its scope. Only the hardware reset input clears the block's state. The software reset bit never does.

Top module: `uart_xfeat_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both held registers are cleared to 0x00, and that includes the feature-enable bit (IER bit 5) and modem-control bits 2 and 7.
- R2: `ext_rst_o` is 1 whenever `rst_n` is 0, or whenever IER bit 5 and MCR bit 2 are both 1. In every other case it is 0.
- R3: Setting MCR bit 2 with the feature enabled changes no held register bit. IER and MCR read back the values written.
- R4: When IER bit 5 and MCR bit 7 are both 1, every bit of `clk_en_o` is 0. In every other case every bit is 1.
- R5: During power-down, host writes to either register still take effect on the next clock edge.
- R6: Clearing MCR bit 7 brings back all clock enables in the cycle after the write. Every other register bit is unchanged.
- R7: With IER bit 5 set, `isr_o` bit 4 equals the inverse of `txrdy_i` and `isr_o` bit 5 equals the inverse of `rxrdy_i`.
- R8: With IER bit 5 clear, `isr_o` bits 4 and 5 read 0, and MCR bits 2 and 7 affect neither `ext_rst_o` nor `clk_en_o`.
- R9: `isr_o` bits 0 to 3, 6 and 7 always equal the same bits of `isr_base_i`.
- R10: A write strobe loads only its own register from `wdata_i` at the next edge. Both strobes in one cycle load both registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| wr_ier_i | input | 1 | Load strobe for the interrupt-enable register |
| wr_mcr_i | input | 1 | Load strobe for the modem-control register |
| wdata_i | input | 8 | Host write data |
| txrdy_i | input | 1 | Internal transmit-ready status |
| rxrdy_i | input | 1 | Internal receive-ready status |
| isr_base_i | input | 8 | Interrupt-status byte from the rest of the UART |
| ier_o | output | 8 | Interrupt-enable register readback |
| mcr_o | output | 8 | Modem-control register readback |
| isr_o | output | 8 | Interrupt-status byte with the ready flags merged in |
| ext_rst_o | output | 1 | Reset output to the external device, active high |
| clk_en_o | output | 2 | Clock enables, bit 0 for baud and bit 1 for oscillator, 1 = running |

## Verification
The assertions check on every cycle that the reset pin follows the active software reset, that the clock enables are low exactly in power-down, that the status bits follow the inverted ready inputs or sit at zero, that the bits outside the ready flags pass through unchanged, and that each write strobe loads its own register. Other behaviour shows only across a sequence, and only the bench scenarios can show it. These cases are: registers that survive a software reset and a power-down period, clocks that come back as soon as the power-down bit is cleared, and a hardware reset that wipes an enabled configuration and holds the external pin high.

// File: rtl/ufe_pkg.sv
// Package: shared control type for the enhanced-feature block.
// Assumes: consumers decode the held registers into this struct once.
package ufe_pkg;
    typedef struct packed {
        logic en;     // feature-enable bit seen in IER
        logic srst;   // software reset request, already gated by en
        logic pdown;  // power-down request, already gated by en
    } ufe_ctl_t;
endpackage

// File: rtl/ufe_regs.sv
// Module: ufe_regs
// Holds the interrupt-enable and modem-control copies that host strobes load.
// Assumes: rst_n is the hardware reset only; no other source may clear these.
module ufe_regs #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ier_i,
    input  logic             wr_mcr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ier_q,
    output logic [REG_W-1:0] mcr_q
);
    // Interrupt-enable copy: cleared by hardware reset, loaded on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        ier_q <= '0;
        else if (wr_ier_i) ier_q <= wdata_i;
    end

    // Modem-control copy: cleared by hardware reset, loaded on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        mcr_q <= '0;
        else if (wr_mcr_i) mcr_q <= wdata_i;
    end

    // Remembers that the last edge was a reset edge, for the reset check.
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1)
            reset_clear_chk: assert (ier_q == '0 && mcr_q == '0);
    end

    // R10
    ier_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ier_i |=> ier_q == $past(wdata_i));
    // R10
    mcr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mcr_i |=> mcr_q == $past(wdata_i));
    // R3
    ier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ier_i |=> $stable(ier_q));
    // R3
    mcr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mcr_i |=> $stable(mcr_q));
endmodule

// File: rtl/ufe_decode.sv
// Module: ufe_decode
// Turns the held register bits into gated feature requests.
// Assumes: bit positions are the ones the UART's host software expects.
module ufe_decode
    import ufe_pkg::*;
#(
    parameter int REG_W        = 8,
    parameter int IER_EN_BIT   = 5,
    parameter int MCR_SRST_BIT = 2,
    parameter int MCR_PD_BIT   = 7
) (
    input  logic [REG_W-1:0] ier_q,
    input  logic [REG_W-1:0] mcr_q,
    output ufe_ctl_t         ctl_o
);
    // Feature requests exist only while the enable bit is set.
    always_comb begin
        ctl_o.en    = ier_q[IER_EN_BIT];
        ctl_o.srst  = ier_q[IER_EN_BIT] & mcr_q[MCR_SRST_BIT];
        ctl_o.pdown = ier_q[IER_EN_BIT] & mcr_q[MCR_PD_BIT];
    end
endmodule

// File: rtl/ufe_rst_out.sv
// Module: ufe_rst_out
// Drives the external reset pin from the hardware reset and the soft request.
// Assumes: the pin is active high and the downstream device samples it itself.
module ufe_rst_out (
    input  logic rst_n,
    input  logic srst_i,
    output logic ext_rst_o
);
    // Either reset source asserts the external pin.
    assign ext_rst_o = !rst_n | srst_i;
endmodule

// File: rtl/ufe_clk_gate.sv
// Module: ufe_clk_gate
// Produces the clock enables that power-down stops. The register clock is never stopped.
// Assumes: the enables feed glitch-free gating cells outside this block.
module ufe_clk_gate #(
    parameter int CLK_EN_N = 2
) (
    input  logic                pdown_i,
    output logic [CLK_EN_N-1:0] clk_en_o
);
    // One enable per gated clock domain, all following the same request.
    for (genvar g = 0; g < CLK_EN_N; g++) begin : g_en
        assign clk_en_o[g] = !pdown_i;
    end
endmodule

// File: rtl/ufe_isr_mux.sv
// Module: ufe_isr_mux
// Merges the inverted ready flags into the interrupt-status byte.
// Assumes: the base byte comes from the rest of the UART, and its flag positions are replaced here.
module ufe_isr_mux #(
    parameter int REG_W  = 8,
    parameter int TX_BIT = 4,
    parameter int RX_BIT = 5
) (
    input  logic             en_i,
    input  logic             txrdy_i,
    input  logic             rxrdy_i,
    input  logic [REG_W-1:0] base_i,
    output logic [REG_W-1:0] isr_o
);
    // Per bit: a flag slot takes the inverted ready or 0, and the other bits pass through.
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b == TX_BIT) begin : g_tx
            assign isr_o[b] = en_i & !txrdy_i;
        end else if (b == RX_BIT) begin : g_rx
            assign isr_o[b] = en_i & !rxrdy_i;
        end else begin : g_pass
            assign isr_o[b] = base_i[b];
        end
    end

    // The base byte's own values at the flag slots are replaced.
    logic unused_base;
    assign unused_base = base_i[TX_BIT] ^ base_i[RX_BIT];

    // R7
    always_comb begin
        if (en_i === 1'b1 && !$isunknown({txrdy_i, rxrdy_i}))
            flag_invert_chk: assert (isr_o[TX_BIT] == !txrdy_i && isr_o[RX_BIT] == !rxrdy_i);
    end
    // R8
    always_comb begin
        if (en_i === 1'b0)
            flag_zero_chk: assert (isr_o[TX_BIT] == 1'b0 && isr_o[RX_BIT] == 1'b0);
    end
endmodule

// File: rtl/uart_xfeat_ctrl.sv
// Module: uart_xfeat_ctrl (top)
// Enhanced-feature control: soft reset out, power-down clock stop, and inverted ready flags.
// Assumes: synchronous active-low hardware reset. Host strobes are one cycle wide per write.
module uart_xfeat_ctrl
    import ufe_pkg::*;
#(
    parameter int REG_W        = 8,
    parameter int IER_EN_BIT   = 5,
    parameter int MCR_SRST_BIT = 2,
    parameter int MCR_PD_BIT   = 7,
    parameter int ISR_TX_BIT   = 4,
    parameter int ISR_RX_BIT   = 5,
    parameter int CLK_EN_N     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ier_i,
    input  logic                wr_mcr_i,
    input  logic [REG_W-1:0]    wdata_i,
    input  logic                txrdy_i,
    input  logic                rxrdy_i,
    input  logic [REG_W-1:0]    isr_base_i,
    output logic [REG_W-1:0]    ier_o,
    output logic [REG_W-1:0]    mcr_o,
    output logic [REG_W-1:0]    isr_o,
    output logic                ext_rst_o,
    output logic [CLK_EN_N-1:0] clk_en_o
);
    localparam logic [REG_W-1:0] PASS_MASK =
        ~((REG_W'(1) << ISR_TX_BIT) | (REG_W'(1) << ISR_RX_BIT));

    logic [REG_W-1:0] ier_q;
    logic [REG_W-1:0] mcr_q;
    ufe_ctl_t         ctl;

    ufe_regs #(.REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ier_i (wr_ier_i),
        .wr_mcr_i (wr_mcr_i),
        .wdata_i  (wdata_i),
        .ier_q    (ier_q),
        .mcr_q    (mcr_q)
    );

    ufe_decode #(
        .REG_W        (REG_W),
        .IER_EN_BIT   (IER_EN_BIT),
        .MCR_SRST_BIT (MCR_SRST_BIT),
        .MCR_PD_BIT   (MCR_PD_BIT)
    ) u_decode (
        .ier_q (ier_q),
        .mcr_q (mcr_q),
        .ctl_o (ctl)
    );

    ufe_rst_out u_rst_out (
        .rst_n     (rst_n),
        .srst_i    (ctl.srst),
        .ext_rst_o (ext_rst_o)
    );

    ufe_clk_gate #(.CLK_EN_N(CLK_EN_N)) u_clk_gate (
        .pdown_i  (ctl.pdown),
        .clk_en_o (clk_en_o)
    );

    ufe_isr_mux #(
        .REG_W  (REG_W),
        .TX_BIT (ISR_TX_BIT),
        .RX_BIT (ISR_RX_BIT)
    ) u_isr (
        .en_i    (ctl.en),
        .txrdy_i (txrdy_i),
        .rxrdy_i (rxrdy_i),
        .base_i  (isr_base_i),
        .isr_o   (isr_o)
    );

    // Readback of the held registers for the host read path.
    assign ier_o = ier_q;
    assign mcr_o = mcr_q;

    // R2
    soft_rst_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[IER_EN_BIT] && mcr_q[MCR_SRST_BIT]) |-> ext_rst_o);
    // R8
    no_soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_q[IER_EN_BIT] |-> !ext_rst_o);
    // R4
    pdown_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[IER_EN_BIT] && mcr_q[MCR_PD_BIT]) |-> clk_en_o == '0);
    // R6
    run_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ier_q[IER_EN_BIT] && mcr_q[MCR_PD_BIT]) |-> &clk_en_o);
    // R9
    isr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_o & PASS_MASK) == (isr_base_i & PASS_MASK));
endmodule

// File: tb/uart_xfeat_ctrl_bench.sv
`timescale 1ns/1ps
module uart_xfeat_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_ier = 1'b0;
    logic       wr_mcr = 1'b0;
    logic [7:0] wdata = '0;
    logic       txrdy = 1'b0;
    logic       rxrdy = 1'b0;
    logic [7:0] isr_base = '0;
    logic [7:0] ier_o, mcr_o, isr_o;
    logic       ext_rst_o;
    logic [1:0] clk_en_o;

    always #2.5 clk = ~clk;

    uart_xfeat_ctrl u_uart_xfeat_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ier_i   (wr_ier),
        .wr_mcr_i   (wr_mcr),
        .wdata_i    (wdata),
        .txrdy_i    (txrdy),
        .rxrdy_i    (rxrdy),
        .isr_base_i (isr_base),
        .ier_o      (ier_o),
        .mcr_o      (mcr_o),
        .isr_o      (isr_o),
        .ext_rst_o  (ext_rst_o),
        .clk_en_o   (clk_en_o)
    );

    typedef struct {
        string      req;
        logic [7:0] ier;
        logic [7:0] mcr;
        logic [7:0] isr;
        logic       xrst;
        logic [1:0] cen;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    logic [7:0] m_ier = '0;
    logic [7:0] m_mcr = '0;

    // Compares one field and counts it.
    task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drives one cycle of stimulus and pushes the outputs expected after the next edge.
    task automatic step(string req, bit rn, bit wi, bit wm, logic [7:0] d,
                        bit tx, bit rx, logic [7:0] base);
        exp_t e;
        bit   en;
        @(negedge clk);
        rst_n = rn; wr_ier = wi; wr_mcr = wm; wdata = d;
        txrdy = tx; rxrdy = rx; isr_base = base;
        if (!rn) begin
            m_ier = '0; m_mcr = '0;
        end else begin
            if (wi) m_ier = d;
            if (wm) m_mcr = d;
        end
        en     = m_ier[5];
        e.req  = req;
        e.ier  = m_ier;
        e.mcr  = m_mcr;
        e.isr  = (base & 8'hCF) | {2'b00, en & !rx, en & !tx, 4'b0000};
        e.xrst = !rn | (en & m_mcr[2]);
        e.cen  = (en & m_mcr[7]) ? 2'b00 : 2'b11;
        exp_q.push_back(e);
    endtask

    // Monitor: after each edge, pops one expected item and compares it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.req, "ier",  ier_o, e.ier);
                cmp(e.req, "mcr",  mcr_o, e.mcr);
                cmp(e.req, "isr",  isr_o, e.isr);
                cmp(e.req, "xrst", {7'd0, ext_rst_o}, {7'd0, e.xrst});
                cmp(e.req, "cen",  {6'd0, clk_en_o}, {6'd0, e.cen});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #50000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step("R1", 0, 0, 0, 8'h00, 1, 1, 8'h00);
        step("R1", 0, 1, 1, 8'hFF, 0, 0, 8'h00);
        // R8: disabled, MCR bits 2 and 7 have no effect; flags read 0
        step("R8", 1, 0, 1, 8'h84, 0, 0, 8'h00);
        step("R8", 1, 0, 0, 8'h00, 1, 0, 8'hFF);
        // R9: pass-through patterns
        step("R9", 1, 0, 0, 8'h00, 0, 1, 8'hA5);
        // R7: enable, then power-down and soft reset already requested
        step("R7", 1, 1, 0, 8'h20, 0, 1, 8'h5A);
        step("R7", 1, 0, 0, 8'h00, 1, 0, 8'hFF);
        step("R2", 1, 0, 0, 8'h00, 1, 1, 8'h00);
        step("R4", 1, 0, 0, 8'h00, 0, 0, 8'h00);
        // R5: writes accepted during power-down
        step("R5", 1, 1, 0, 8'h2F, 0, 0, 8'h00);
        step("R5", 1, 0, 1, 8'h86, 0, 0, 8'h00);
        // R3: soft reset leaves the registers intact
        step("R3", 1, 0, 0, 8'h00, 1, 0, 8'h33);
        // R6: clearing power-down restores clocks at once
        step("R6", 1, 0, 1, 8'h06, 1, 1, 8'h00);
        step("R6", 1, 0, 0, 8'h00, 1, 1, 8'h00);
        // R2: soft reset released
        step("R2", 1, 0, 1, 8'h02 & 8'h00, 0, 1, 8'h00);
        // R10: both strobes in one cycle, then each alone
        step("R10", 1, 1, 1, 8'hA4, 0, 0, 8'h81);
        step("R10", 1, 1, 0, 8'h21, 1, 1, 8'h00);
        step("R10", 1, 0, 1, 8'h80, 1, 1, 8'h00);
        // R1: hardware reset wipes an enabled configuration
        step("R1", 0, 0, 0, 8'h00, 0, 0, 8'h00);
        step("R8", 1, 0, 1, 8'h84, 0, 0, 8'h3C);
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule